// File: doc/BRIEF.md
# DDR Refresh Scheduler with Deferral Credit

This block keeps a DDR SDRAM refreshed on behalf of a memory controller. An internal interval timer produces one refresh obligation per refresh interval, and the obligations pile up in a small debt counter. The main command scheduler keeps the command bus while it has traffic. Whenever it raises `bus_grant`, the refresh engine takes the bus and pays off its debt. The engine first closes every bank with a precharge-all command. It waits the row-precharge time, issues an auto refresh, and holds the bus for the refresh cycle time. While debt remains it issues further auto refreshes back to back, one refresh cycle time apart, without a new precharge.

If the main scheduler defers refresh for too long, the debt reaches a threshold. The block then raises `ref_urgent` and takes the bus whether or not it was granted. This caps the outstanding refreshes at eight. The block drives the raw DRAM command pins directly. While it owns the bus it keeps `ref_busy` high, and the main scheduler must then leave the command pins alone. All timing values are parameters in clock cycles.

Top module: `refresh_sched`

## Requirements
- R1: During and right after reset the pins carry deselect (cs_n=1, ras_n=1, cas_n=1, we_n=1), cke=1 and addr=0, and ref_busy, ref_pending and ref_urgent are 0.
- R2: The interval timer adds one unit of debt every T_REFI cycles. The first unit becomes visible on ref_pending after the T_REFI-th clock edge following reset release.
- R3: The debt falls by one for each auto refresh issued. ref_pending is 1 exactly when the debt is nonzero.
- R4: When the engine is idle, the debt is nonzero and bus_grant is 1 (or urgency holds), a precharge-all is issued in the next cycle. It is encoded cs_n=0, ras_n=0, cas_n=1, we_n=0, with addr bit 10 set and all other address bits 0. When the engine is idle without grant or urgency, the pins stay at deselect and ref_busy stays 0.
- R5: The first auto refresh of a burst is issued exactly T_RP cycles after the precharge-all. The cycles in between carry deselect.
- R6: Auto refresh is encoded cs_n=0, ras_n=0, cas_n=0, we_n=1 with cke=1 and addr=0.
- R7: For the T_RFC-1 cycles after an auto refresh, the pins carry deselect and ref_busy stays 1.
- R8: T_RFC cycles after an auto refresh, another auto refresh follows with no precharge if the debt is still nonzero and bus_grant or urgency holds. Otherwise the engine releases the bus.
- R9: ref_urgent is 1 exactly when the debt is at least URGENT_TH (default 7). Urgency starts a refresh even with bus_grant low.
- R10: The debt never exceeds eight, and the gap between consecutive auto refreshes never exceeds 8*T_REFI cycles.
- R11: ref_busy is 1 from the precharge-all cycle through the cycle before release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_grant | input | 1 | Main scheduler allows refresh to take the command bus |
| cs_n | output | 1 | DRAM chip select, active low |
| ras_n | output | 1 | DRAM row strobe, active low |
| cas_n | output | 1 | DRAM column strobe, active low |
| we_n | output | 1 | DRAM write enable, active low |
| cke | output | 1 | DRAM clock enable, held high |
| addr | output | ADDR_W | DRAM address; bit 10 selects all banks on precharge, else zero |
| ref_busy | output | 1 | Refresh engine owns the command bus |
| ref_pending | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | Debt has reached the forcing threshold |

## Verification
The hardest situation to reach is urgency overriding a withheld grant while an interval tick lands inside a running burst. Reaching it needs long stretches with the bus denied. The stimulus therefore sweeps the number of denied intervals from zero past the threshold, then grants the bus, and also sends short grant pulses that end mid-burst. A monitor keeps an arithmetic debt model from elapsed cycles and observed refreshes. It checks every cycle of the command trace against it, including the catch-up-or-release decision after each refresh cycle time.

// File: rtl/refresh_pkg.sv
// Package refresh_pkg
// Shared state type and DRAM command encodings for the refresh scheduler.
// Assumes the command is formed by the four active-low strobes in the order
// cs_n, ras_n, cas_n, we_n.
package refresh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PREA     = 3'd1,
        ST_WAIT_RP  = 3'd2,
        ST_AREF     = 3'd3,
        ST_WAIT_RFC = 3'd4
    } rs_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } dram_cmd_t;

    localparam dram_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam dram_cmd_t CMD_PREA  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam dram_cmd_t CMD_AREF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    // Address bit that turns a precharge into a precharge of every bank.
    localparam int unsigned ALL_BANK_BIT = 10;

endpackage

// File: rtl/refi_timer.sv
// Module refi_timer
// Free-running interval counter. Emits a one-cycle tick once per T_REFI
// cycles; the first tick is in the cycle T_REFI-1 edges after reset release.
// Assumes T_REFI >= 2.
module refi_timer #(
    parameter int unsigned T_REFI = 780
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned TW = $clog2(T_REFI);
    localparam logic [TW-1:0] LAST = TW'(T_REFI - 1);

    logic [TW-1:0] cnt;

    // Wrap the counter at the interval length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Tick marks the final cycle of each interval.
    always_comb begin
        tick = (cnt == LAST);
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/refresh_debt.sv
// Module refresh_debt
// Counts refreshes owed: up on each interval tick, down on each issued auto
// refresh. Flags pending (debt nonzero) and urgent (debt at threshold).
// Assumes the sequencer never issues a refresh with zero debt and that
// URGENT_TH < DEBT_MAX.
module refresh_debt #(
    parameter int unsigned DEBT_MAX  = 8,
    parameter int unsigned URGENT_TH = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic issue,
    output logic pending,
    output logic urgent
);
    // One spare bit so an overflow would be visible rather than wrap.
    localparam int unsigned DW = $clog2(DEBT_MAX + 2);
    localparam logic [DW-1:0] TH  = DW'(URGENT_TH);
    localparam logic [DW-1:0] MAX = DW'(DEBT_MAX);

    logic [DW-1:0] debt;

    // Net change of tick minus issue per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt <= '0;
        end else begin
            case ({tick, issue})
                2'b10:   debt <= debt + 1'b1;
                2'b01:   debt <= debt - 1'b1;
                default: debt <= debt;
            endcase
        end
    end

    // Status flags derived from the count.
    always_comb begin
        pending = (debt != '0);
        urgent  = (debt >= TH);
    end

    // R10
    debt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        debt <= MAX);

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> debt != '0);

    // R3
    debt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !issue) |=> debt == $past(debt) + 1'b1);

endmodule

// File: rtl/refresh_fsm.sv
// Module refresh_fsm
// Sequencer: precharge-all, wait T_RP, auto refresh, wait T_RFC, then either
// a further auto refresh (banks already idle) or release of the bus.
// Assumes T_RP >= 2 and T_RFC >= 2 and that the main scheduler leaves the
// pins alone while busy is high.
module refresh_fsm
    import refresh_pkg::*;
#(
    parameter int unsigned T_RP  = 4,
    parameter int unsigned T_RFC = 44
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      grant,
    input  logic      pending,
    input  logic      urgent,
    output rs_state_t state,
    output logic      busy,
    output logic      issue_ref
);
    localparam int unsigned LONGEST = (T_RFC > T_RP) ? T_RFC : T_RP;
    localparam int unsigned CW      = $clog2(LONGEST + 1);
    localparam logic [CW-1:0] RP_LOAD  = CW'(T_RP - 1);
    localparam logic [CW-1:0] RFC_LOAD = CW'(T_RFC - 1);

    logic [CW-1:0] wait_cnt;
    logic          go;

    // Refresh may proceed when owed and either granted or forced.
    always_comb begin
        go = pending && (grant || urgent);
    end

    // State progression and wait countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (go) state <= ST_PREA;
                end
                ST_PREA: begin
                    wait_cnt <= RP_LOAD;
                    state    <= ST_WAIT_RP;
                end
                ST_WAIT_RP: begin
                    wait_cnt <= wait_cnt - 1'b1;
                    if (wait_cnt == CW'(1)) state <= ST_AREF;
                end
                ST_AREF: begin
                    wait_cnt <= RFC_LOAD;
                    state    <= ST_WAIT_RFC;
                end
                ST_WAIT_RFC: begin
                    wait_cnt <= wait_cnt - 1'b1;
                    if (wait_cnt == CW'(1)) state <= go ? ST_AREF : ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus ownership and refresh strobe.
    always_comb begin
        busy      = (state != ST_IDLE);
        issue_ref = (state == ST_AREF);
    end

    // R4
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !grant && !urgent) |=> state == ST_IDLE);

    // R9
    urgent_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && urgent) |=> state == ST_PREA);

    // R5
    aref_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AREF) |-> ($past(state) == ST_WAIT_RP || $past(state) == ST_WAIT_RFC));

    // R8
    no_prea_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREA) |-> $past(state) == ST_IDLE);

endmodule

// File: rtl/refresh_cmd_enc.sv
// Module refresh_cmd_enc
// Maps the sequencer state to DRAM pins. Precharge-all sets the all-bank
// address bit; every other address bit is zero. CKE is held high.
// Assumes ADDR_W > ALL_BANK_BIT.
module refresh_cmd_enc
    import refresh_pkg::*;
#(
    parameter int unsigned ADDR_W = 14
) (
    input  rs_state_t         state,
    output dram_cmd_t         cmd,
    output logic              cke,
    output logic [ADDR_W-1:0] addr
);
    // Pin pattern per state.
    always_comb begin
        cmd  = CMD_DESEL;
        addr = '0;
        cke  = 1'b1;
        case (state)
            ST_PREA: begin
                cmd                = CMD_PREA;
                addr[ALL_BANK_BIT] = 1'b1;
            end
            ST_AREF: cmd = CMD_AREF;
            default: cmd = CMD_DESEL;
        endcase
    end

endmodule

// File: rtl/refresh_sched.sv
// Module refresh_sched
// Top of the refresh scheduler: interval timer, debt counter, sequencer and
// pin encoder. Drives DRAM command pins whenever ref_busy is high.
// Assumes T_REFI > T_RP + T_RFC so a forced burst finishes within an interval.
module refresh_sched
    import refresh_pkg::*;
#(
    parameter int unsigned T_REFI    = 780,
    parameter int unsigned T_RP      = 4,
    parameter int unsigned T_RFC     = 44,
    parameter int unsigned DEBT_MAX  = 8,
    parameter int unsigned URGENT_TH = 7,
    parameter int unsigned ADDR_W    = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_grant,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cke,
    output logic [ADDR_W-1:0] addr,
    output logic              ref_busy,
    output logic              ref_pending,
    output logic              ref_urgent
);
    logic      tick;
    logic      issue_ref;
    rs_state_t state;
    dram_cmd_t cmd;

    refi_timer #(.T_REFI(T_REFI)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    refresh_debt #(.DEBT_MAX(DEBT_MAX), .URGENT_TH(URGENT_TH)) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .issue   (issue_ref),
        .pending (ref_pending),
        .urgent  (ref_urgent)
    );

    refresh_fsm #(.T_RP(T_RP), .T_RFC(T_RFC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (bus_grant),
        .pending   (ref_pending),
        .urgent    (ref_urgent),
        .state     (state),
        .busy      (ref_busy),
        .issue_ref (issue_ref)
    );

    refresh_cmd_enc #(.ADDR_W(ADDR_W)) u_enc (
        .state (state),
        .cmd   (cmd),
        .cke   (cke),
        .addr  (addr)
    );

    // Unpack the command onto the pins.
    always_comb begin
        cs_n  = cmd.cs_n;
        ras_n = cmd.ras_n;
        cas_n = cmd.cas_n;
        we_n  = cmd.we_n;
    end

    // R6
    aref_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ref |-> (!cs_n && !ras_n && !cas_n && we_n && cke && addr == '0));

    // R11
    busy_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_busy |-> (cs_n && ras_n && cas_n && we_n));

endmodule

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
    localparam int T_REFI = 40;
    localparam int T_RP   = 3;
    localparam int T_RFC  = 10;
    localparam int URG    = 7;
    localparam int AW     = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_grant = 1'b0;
    logic          cs_n, ras_n, cas_n, we_n, cke;
    logic [AW-1:0] addr;
    logic          ref_busy, ref_pending, ref_urgent;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    refresh_sched #(
        .T_REFI(T_REFI), .T_RP(T_RP), .T_RFC(T_RFC),
        .DEBT_MAX(8), .URGENT_TH(URG), .ADDR_W(AW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
        .addr(addr), .ref_busy(ref_busy), .ref_pending(ref_pending),
        .ref_urgent(ref_urgent)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Edges counted since reset release.
    int edges = 0;
    always @(posedge clk) if (rst_n) edges <= edges + 1;

    // Monitor state.
    int  refs_seen = 0;
    int  model, prev_model = 0;
    bit  prev_grant = 0, prev_busy = 0, exp_pre = 0;
    int  since_pre = -1, since_ref = -1, last_ref_edge = -1;
    bit  is_pre, is_ref, is_desel;

    always @(negedge clk) begin
        if (rst_n && edges > 0) begin
            model    = edges / T_REFI - refs_seen;
            is_pre   = !cs_n && !ras_n && cas_n && !we_n;
            is_ref   = !cs_n && !ras_n && !cas_n && we_n;
            is_desel = cs_n && ras_n && cas_n && we_n;

            // R3 pending tracks debt; R9 urgent at threshold; R10 bound
            check(ref_pending == (model > 0), "R3", ref_pending, model > 0);
            check(ref_urgent == (model >= URG), "R9", ref_urgent, model >= URG);
            check(model <= 8, "R10", model, 8);

            // R4 start or stay idle
            if (exp_pre) begin
                check(is_pre, "R4", is_pre, 1);
            end else if (!prev_busy && since_ref != T_RFC) begin
                check(!ref_busy && is_desel, "R4", ref_busy, 0);
            end

            if (is_pre) begin
                check(addr == AW'(1 << 10), "R4", addr, 1 << 10);
                check(ref_busy, "R11", ref_busy, 1);
                since_pre = 0;
            end else if (since_pre >= 1 && since_pre < T_RP) begin
                check(is_desel && ref_busy, "R5", is_desel, 1);
            end else if (since_pre == T_RP) begin
                check(is_ref, "R5", is_ref, 1);
            end

            if (since_ref >= 1 && since_ref < T_RFC) begin
                check(is_desel && ref_busy, "R7", is_desel, 1);
            end else if (since_ref == T_RFC) begin
                if (prev_model > 0 && (prev_grant || prev_model >= URG))
                    check(is_ref, "R8", is_ref, 1);
                else
                    check(!ref_busy && is_desel, "R8", ref_busy, 0);
                if (!ref_busy && prev_grant)
                    check(prev_model == 0, "R8", prev_model, 0);
            end

            if (is_ref) begin
                check(cke && addr == '0, "R6", addr, 0);
                check(ref_busy, "R11", ref_busy, 1);
                if (last_ref_edge >= 0)
                    check(edges - last_ref_edge <= 8 * T_REFI, "R10",
                          edges - last_ref_edge, 8 * T_REFI);
                last_ref_edge = edges;
                since_ref = 0;
                refs_seen++;
                model--;
            end

            exp_pre    = !ref_busy && model > 0 && (bus_grant || model >= URG);
            prev_model = model;
            prev_grant = bus_grant;
            prev_busy  = ref_busy;
            if (since_pre >= 0) since_pre++;
            if (since_pre > T_RP) since_pre = -1;
            if (since_ref >= 0) since_ref++;
            if (since_ref > T_RFC) since_ref = -1;
        end
    end

    task automatic set_grant(input bit v);
        @(posedge clk);
        #1 bus_grant = v;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(cs_n && ras_n && cas_n && we_n, "R1", {cs_n, ras_n, cas_n, we_n}, 15);
        check(cke == 1'b1 && addr == '0, "R1", addr, 0);
        check(!ref_busy && !ref_pending && !ref_urgent, "R1",
              {ref_busy, ref_pending, ref_urgent}, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 first debt unit after T_REFI edges
        wait (edges == T_REFI - 1);
        @(negedge clk);
        check(!ref_pending, "R2", ref_pending, 0);
        @(negedge clk);
        check(ref_pending, "R2", ref_pending, 1);

        // Sweep: deny the bus for d intervals, then grant.
        for (int d = 0; d <= 10; d++) begin
            set_grant(1'b0);
            idle_cycles(d * T_REFI);
            set_grant(1'b1);
            idle_cycles(3 * T_REFI);
            @(negedge clk);
            check(!ref_urgent, "R9", ref_urgent, 0);
        end

        // Short grant pulses that end mid-burst.
        for (int p = 0; p < 12; p++) begin
            set_grant(1'b0);
            idle_cycles(2 * T_REFI + 7 * p);
            set_grant(1'b1);
            set_grant(1'b0);
        end

        // Long denial: only urgency refreshes.
        set_grant(1'b0);
        idle_cycles(20 * T_REFI);
        @(negedge clk);
        check(last_ref_edge >= 0 && edges - last_ref_edge <= T_REFI + T_RP + 2, "R9",
              edges - last_ref_edge, T_REFI);
        set_grant(1'b1);
        idle_cycles(2 * T_REFI);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule